// File: doc/BRIEF.md
# Fractional Divisor Baud Tick Generator

This block makes the oversampling tick that a serial transmitter and receiver use to shift and sample bits. The core clock passes through an optional divide-by-four stage. It is then divided by a programmable divisor that has a 16-bit integer part and a 4-bit fraction counted in sixteenths. The fraction is realised by a 4-bit phase accumulator. Each time the accumulator wraps, one tick period is lengthened by one prescaled clock. Over sixteen ticks the mean period is therefore integer + fraction/16.

A register write port loads the divisor bytes, the fraction, the prescaler select and the oversampling mode. Any write restarts the divider, the accumulator and the bit counter. The tick rate depends only on the divisor. The mode (16X, 8X or 4X) sets how many ticks make up one serial bit, and a second output pulses on the tick that ends each bit. In 8X and 4X mode an odd fraction makes bit lengths differ by one prescaled clock from bit to bit.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the integer divisor is 1, the fraction is 0, the prescaler divides by 1 and the mode is 16X. `tick_o` is then high on every core clock and `bit_stb_o` is high on every 16th of them.
- R2: The register map is: address 0 is the integer low byte and address 1 is the integer high byte. Address 2 holds the fraction; only data bits 3:0 are kept and bits 7:4 are ignored. Address 3 is control: bit 7 selects the prescaler, bit 4 selects 8X and bit 5 selects 4X.
- R3: With fraction 0 and the prescaler at divide-by-1, ticks come every D core clocks, where D is the integer divisor.
- R4: With control bit 7 set, the divider advances once every 4 core clocks, so every tick period is 4 times longer.
- R5: The k-th tick after a restart (k = 1, 2, …) falls in cycle S·(k·D + floor((k−1)·F/16)) − 1. S is the prescale factor (1 or 4), F is the fraction, and cycle 0 is the first cycle after the write edge.
- R6: `bit_stb_o` is high only together with `tick_o`, on ticks N, 2N, 3N, … after a restart. N is 16, 8 or 4 for the 16X, 8X or 4X mode.
- R7: When control bits 4 and 5 are both set, the block behaves as 4X mode.
- R8: An integer divisor of 0 behaves exactly as a divisor of 1.
- R9: A write to any address restarts the prescaler, divider, accumulator and bit counter. The first tick then comes S·D − 1 cycles after the write edge.
- R10: `tick_o` is never high on two consecutive cycles unless the effective integer divisor is 1 and the prescaler divides by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| tick_o | output | 1 | Oversampling tick, one core clock wide |
| bit_stb_o | output | 1 | Pulse on the tick that ends a serial bit |

## Verification
The bench sweeps all sixteen fractions over small divisors, long enough for the accumulator to wrap, and compares every cycle with the closed-form tick position. An accumulator whose carry is off by one tick, or that stretches the wrong period, moves a tick by one cycle and is caught. Separate runs cover the prescaler, a two-byte divisor, a zero divisor, the 8X and 4X bit lengths with odd fractions, the case with both mode bits set, and fraction bits above bit 3 being ignored. A design that drops these bits, that stops on a zero divisor, or that lets 8X override 4X produces wrong tick or strobe cycles. Each run starts from a fresh write, so a block that keeps its old phase across a write misplaces the first tick.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PRE_RATIO = 4;

  localparam logic [ADDR_W-1:0] A_DIV_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_FRAC   = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd3;

  localparam int unsigned CTL_PRESC = 7;
  localparam int unsigned CTL_OS8   = 4;
  localparam int unsigned CTL_OS4   = 5;

  typedef enum logic [1:0] {OS_16X = 2'd0, OS_8X = 2'd1, OS_4X = 2'd2} os_mode_e;

  typedef struct packed {
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              presc;
    os_mode_e          mode;
  } baud_cfg_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import frac_baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output baud_cfg_t         cfg_o,
  output logic              clr_o
);
  localparam int unsigned HALF = INT_W / 2;

  logic [HALF-1:0]   lo_q, hi_q;
  logic [FRAC_W-1:0] frac_q;
  logic              presc_q, os8_q, os4_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= HALF'(1);
      hi_q    <= '0;
      frac_q  <= '0;
      presc_q <= 1'b0;
      os8_q   <= 1'b0;
      os4_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_DIV_LO: lo_q   <= wr_data_i[HALF-1:0];
        A_DIV_HI: hi_q   <= wr_data_i[HALF-1:0];
        A_FRAC:   frac_q <= wr_data_i[FRAC_W-1:0];
        default: begin
          presc_q <= wr_data_i[CTL_PRESC];
          os8_q   <= wr_data_i[CTL_OS8];
          os4_q   <= wr_data_i[CTL_OS4];
        end
      endcase
    end
  end

  // 4X wins over 8X
  always_comb begin
    cfg_o.div_int  = {hi_q, lo_q};
    cfg_o.div_frac = frac_q;
    cfg_o.presc    = presc_q;
    if (os4_q)      cfg_o.mode = OS_4X;
    else if (os8_q) cfg_o.mode = OS_8X;
    else            cfg_o.mode = OS_16X;
  end

  assign clr_o = wr_en_i;
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic div_i,
  output logic en_o
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = !div_i || (cnt_q == LAST);

  p_en_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && en_o && !clr_i) |=> !en_o);
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o
);
  localparam int unsigned CW = INT_W + 1;

  logic [CW-1:0]     cnt_q, last;
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q;
  logic [INT_W-1:0]  d_eff;

  assign d_eff  = (div_int_i == '0) ? INT_W'(1) : div_int_i;
  // period = d_eff + stretch; compare against period - 1
  assign last   = {1'b0, d_eff} - CW'(!stretch_q);
  assign tick_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= '0;
      {stretch_q, acc_q} <= {1'b0, acc_q} + {1'b0, div_frac_i};
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  p_stretch_frac_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_q |-> (div_frac_i != '0));
  p_clr_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && acc_q == '0 && !stretch_q));
endmodule

// File: rtl/baud_bit_strobe.sv
module baud_bit_strobe
  import frac_baud_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     tick_i,
  input  os_mode_e mode_i,
  output logic     stb_o
);
  localparam int unsigned CW = 4;

  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    unique case (mode_i)
      OS_8X:   lim = CW'(7);
      OS_4X:   lim = CW'(3);
      default: lim = CW'(15);
    endcase
  end

  assign stb_o = tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= stb_o ? '0 : cnt_q + 1'b1;
  end

  p_bitcnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tick_o,
  output logic              bit_stb_o
);
  baud_cfg_t cfg;
  logic      clr, pre_en;

  baud_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o (cfg),
    .clr_o (clr)
  );

  baud_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i, .rst_ni,
    .clr_i (clr),
    .div_i (cfg.presc),
    .en_o  (pre_en)
  );

  baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .en_i       (pre_en),
    .div_int_i  (cfg.div_int),
    .div_frac_i (cfg.div_frac),
    .tick_o     (tick_o)
  );

  baud_bit_strobe u_bit (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .tick_i (tick_o),
    .mode_i (cfg.mode),
    .stb_o  (bit_stb_o)
  );

  p_stb_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> tick_o);
  p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !wr_en_i && !(cfg.div_int <= INT_W'(1) && !cfg.presc)) |=> !tick_o);
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_o, bit_stb_o;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_o(tick_o), .bit_stb_o(bit_stb_o)
  );

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int d, input int f, input logic [7:0] ctl);
    wr(2'd0, 8'(d & 255));
    wr(2'd1, 8'(d >> 8));
    wr(2'd2, 8'(f));
    wr(2'd3, ctl);
  endtask

  // called in cycle 0 after the restart edge
  task automatic measure(input int d, input int f, input int s, input int n,
                         input int kmax, input string tag);
    int k = 1;
    int errs = 0;
    int nxt = s * d - 1;
    int lim = s * (kmax * d + ((kmax - 1) * f) / 16) - 1;
    #1;
    for (int c = 0; c <= lim; c++) begin
      logic et, eb;
      et = (c == nxt);
      eb = et && (k % n == 0);
      total++;
      if (tick_o !== et || bit_stb_o !== eb) begin
        bad++;
        if (errs < 4)
          $display("FAIL %s d=%0d f=%0d cycle %0d: tick=%b stb=%b expected tick=%b stb=%b",
                   tag, d, f, c, tick_o, bit_stb_o, et, eb);
        errs++;
      end
      if (et) begin
        k++;
        nxt = s * (k * d + ((k - 1) * f) / 16) - 1;
      end
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    measure(1, 0, 1, 16, 40, "R1 reset state");

    // R5 R3: fraction sweep across small divisors, 16X
    for (int d = 1; d <= 3; d++)
      for (int f = 0; f < 16; f++) begin
        setup(d, f, 8'h00);
        measure(d, f, 1, 16, 34, "R5 fraction sweep");
      end

    setup(7, 0, 8'h00);
    measure(7, 0, 1, 16, 18, "R3 integer period");

    // R2: high byte carries weight 256
    setup(16'h0105, 0, 8'h00);
    measure(16'h0105, 0, 1, 16, 3, "R2 two-byte divisor");
    setup(16'h1234, 9, 8'h00);
    measure(16'h1234, 9, 1, 16, 2, "R2 large divisor");

    // R2: fraction bits 7:4 ignored
    setup(2, 8'hF5, 8'h00);
    measure(2, 5, 1, 16, 18, "R2 fraction upper bits");

    // R4: prescaler
    setup(2, 5, 8'h80);
    measure(2, 5, 4, 16, 18, "R4 prescaler");
    setup(1, 0, 8'h80);
    measure(1, 0, 4, 16, 18, "R4 prescaler div1");

    // R6: 8X and 4X bit strobes with odd fractions (jitter)
    setup(2, 1, 8'h10);
    measure(2, 1, 1, 8, 33, "R6 8X odd fraction");
    setup(3, 3, 8'h20);
    measure(3, 3, 1, 4, 33, "R6 4X odd fraction");
    setup(2, 7, 8'h90);
    measure(2, 7, 4, 8, 17, "R6 8X with prescaler");

    // R7: both mode bits -> 4X
    setup(2, 3, 8'h30);
    measure(2, 3, 1, 4, 20, "R7 both mode bits");

    // R8: zero divisor acts as one
    setup(0, 4, 8'h00);
    measure(1, 4, 1, 16, 34, "R8 zero divisor");

    // R9: rewrite mid-period restarts phase
    setup(5, 9, 8'h00);
    repeat (7) @(negedge clk);
    wr(2'd3, 8'h00);
    measure(5, 9, 1, 16, 18, "R9 restart on write");
    setup(4, 0, 8'h80);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'h00);
    measure(4, 0, 4, 16, 3, "R9 restart on fraction write");

    // R10: single-cycle tick already implied by every comparison above
    setup(2, 15, 8'h00);
    measure(2, 15, 1, 16, 34, "R10 single-cycle tick");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule